// File: doc/BRIEF.md
# Addressable Step-Attenuator Control Front End

This block drives the seven control lines of a digital step attenuator. Each line switches one attenuation section into the signal path. The section weights double from 0.25 dB for the lowest code bit up to 16 dB for the highest, so the block covers 0 to 31.75 dB in quarter-decibel steps. The controlling host sets the attenuation in one of two ways. It can shift a 16-bit frame over a three-wire serial port (data, clock and latch enable). It can also drive a seven-bit code onto parallel pins.

A mode pin selects serial or parallel control. In serial mode, each device on a shared bus has a three-bit strap address, so up to eight devices can share the same data, clock and latch lines. Only the device whose strap address matches the frame accepts the update. In parallel mode the latch-enable pin sets the behaviour. While it is high, the code tracks the pins directly. While it is low, the code is frozen, and a rising edge of latch enable captures the pins.

The block runs on one fast system clock. Every control pin is treated as asynchronous and passes through a multi-stage synchronizer, and edges are detected after that. An asynchronous reset restores the power-up state, which is full attenuation.

Top module: `atten_ctrl`

## Requirements
- R1: Reset (asynchronous, active low) forces `atten_o` to all ones (code 127, 31.75 dB). It also sets the serial frame image to attenuation word 0x7F with address byte 0x00.
- R2: `mode_i` = 1 selects serial control and `mode_i` = 0 selects parallel control. In parallel mode, serial clock edges do not alter the frame image.
- R3: In serial mode, each rising edge of `sclk_i` seen while `le_i` is low shifts `sdata_i` into a 16-bit frame, least significant bit first. After 16 shifts, the first bit sent sits at frame bit 0. Frame bits 7:0 form the attenuation word and frame bits 15:8 form the address byte. Bit 7 of the attenuation word is ignored.
- R4: In serial mode, a rising edge of `le_i` copies frame bits 6:0 to `atten_o` when frame bits 10:8 equal `addr_i`. Frame bits 15:11 are don't-care.
- R5: If frame bits 10:8 differ from `addr_i` when `le_i` rises in serial mode, `atten_o` keeps its value.
- R6: While `le_i` is high, `sclk_i` edges do not shift the frame. A later rising edge of `le_i` with no new shifts reloads the frame that was held.
- R7: In parallel mode with `le_i` high, `atten_o` follows `par_i` (direct operation).
- R8: In parallel mode with `le_i` low, changes on `par_i` are ignored. The next rising edge of `le_i` takes the code from `par_i`.
- R9: Any pin change reaches `atten_o` on the third rising edge of `clk_i` after it is applied (with SYNC_STAGES = 2).
- R10: A latch edge acts on whatever 16 bits the frame holds, whether fewer or more than 16 bits were shifted. Surplus early bits drop out of bit 0, and a short burst leaves older bits in the low part of the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 1 = serial control, 0 = parallel control |
| le_i | input | 1 | Latch enable (serial load strobe / parallel direct-or-latched select) |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data, least significant bit first |
| addr_i | input | 3 | Strap address compared against the frame address |
| par_i | input | 7 | Parallel attenuation code |
| atten_o | output | 7 | Active attenuation code, bit n weighs 0.25 dB * 2^n |

## Verification
Each result appears exactly three system-clock edges after the pin change that causes it. Two edges go to the synchronizer and one to the state register. This holds for a latch-enable rise, for a serial clock edge (whose effect is only visible at the next latch) and for a parallel pin change in direct mode. The bench reference model keeps a history of pin values, one per edge. It evaluates the pins seen two edges back and the edge before that, and its result is compared with `atten_o` half a clock later at each falling edge. Directed checks wait at least four cycles after a stimulus. The latency case samples exactly after the second and third edges.

// File: rtl/atten_pkg.sv
package atten_pkg;
   localparam int ATT_CODE_W      = 7;
   localparam int ATT_ADDR_W      = 3;
   localparam int ATT_WORD_W      = 8;
   localparam int ATT_SYNC_STAGES = 2;

   typedef enum logic {
      MODE_PARALLEL = 1'b0,
      MODE_SERIAL   = 1'b1
   } ctl_mode_e;
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("atten_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("atten_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[LAST];
endmodule

// File: rtl/atten_frame_sreg.sv
module atten_frame_sreg #(
   parameter int                FRAME_W = 16,
   parameter logic [FRAME_W-1:0] RST_VAL = '0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               shift_i,
   input  logic               hold_i,
   input  logic               bit_i,
   output logic [FRAME_W-1:0] frame_o
);
   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("atten_frame_sreg: FRAME_W must be at least 2");
      end
   endgenerate

   logic [FRAME_W-1:0] sr_q;

   // New bits enter at the top and walk down, so the first bit sent ends at bit 0.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sr_q <= RST_VAL;
      else if (shift_i) sr_q <= {bit_i, sr_q[FRAME_W-1:1]};
   end

   assign frame_o = sr_q;

   // R6: the frame is frozen while latch enable is high
   a_r6_frozen_le_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i |=> $stable(frame_o));
endmodule

// File: rtl/atten_state.sv
module atten_state #(
   parameter int CODE_W  = 7,
   parameter int ADDR_W  = 3,
   parameter int FRAME_W = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               serial_i,
   input  logic               le_i,
   input  logic               le_rise_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [CODE_W-1:0]  par_i,
   output logic [CODE_W-1:0]  code_o
);
   localparam int HALF_W  = FRAME_W / 2;
   localparam int ADDR_LO = HALF_W;
   localparam int ADDR_HI = HALF_W + ADDR_W - 1;

   generate
      if (CODE_W > HALF_W) begin : g_bad_code
         $error("atten_state: CODE_W exceeds the attenuation word");
      end
      if (ADDR_W > HALF_W) begin : g_bad_addr
         $error("atten_state: ADDR_W exceeds the address byte");
      end
   endgenerate

   logic              addr_hit;
   logic [CODE_W-1:0] frame_code;
   logic              unused_frame_bits;

   assign frame_code = frame_i[CODE_W-1:0];
   assign addr_hit   = (frame_i[ADDR_HI:ADDR_LO] == addr_i);
   assign unused_frame_bits = ^frame_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_o <= '1;
      end else if (serial_i) begin
         if (le_rise_i && addr_hit) code_o <= frame_code;
      end else if (le_i) begin
         code_o <= par_i;
      end
   end

   // R4: an addressed latch edge loads the frame code
   a_r4_match_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (serial_i && le_rise_i && addr_hit) |=> (code_o == $past(frame_i[CODE_W-1:0])));
   // R5: a latch edge for another address leaves the code alone
   a_r5_mismatch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (serial_i && le_rise_i && !addr_hit) |=> $stable(code_o));
   // R7: direct parallel operation tracks the pins
   a_r7_direct_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!serial_i && le_i) |=> (code_o == $past(par_i)));
   // R8: latched parallel operation holds while latch enable is low
   a_r8_latched_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!serial_i && !le_i) |=> $stable(code_o));
endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl
   import atten_pkg::*;
#(
   parameter int CODE_W      = ATT_CODE_W,
   parameter int ADDR_W      = ATT_ADDR_W,
   parameter int WORD_W      = ATT_WORD_W,
   parameter int SYNC_STAGES = ATT_SYNC_STAGES
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mode_i,
   input  logic              le_i,
   input  logic              sclk_i,
   input  logic              sdata_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CODE_W-1:0] par_i,
   output logic [CODE_W-1:0] atten_o
);
   localparam int FRAME_W = 2 * WORD_W;
   localparam int BUN_W   = 4 + ADDR_W + CODE_W;
   localparam logic [BUN_W-1:0]   BUN_RST   = {1'b1, {(BUN_W-1){1'b0}}};
   localparam logic [FRAME_W-1:0] FRAME_RST = {{(FRAME_W-CODE_W){1'b0}}, {CODE_W{1'b1}}};

   generate
      if (CODE_W >= WORD_W) begin : g_bad_code
         $error("atten_ctrl: CODE_W must be narrower than WORD_W");
      end
      if (ADDR_W > WORD_W) begin : g_bad_addr
         $error("atten_ctrl: ADDR_W must fit in WORD_W");
      end
   endgenerate

   logic [BUN_W-1:0]  bun_raw, bun_s;
   logic              mode_bit, le_s, sclk_s, sdata_s;
   logic [ADDR_W-1:0] addr_s;
   logic [CODE_W-1:0] par_s;
   ctl_mode_e         mode_s;
   logic              le_q, sclk_q, le_rise, sclk_rise, shift_en;
   logic [FRAME_W-1:0] frame;

   assign bun_raw = {mode_i, le_i, sclk_i, sdata_i, addr_i, par_i};

   atten_sync #(.W(BUN_W), .STAGES(SYNC_STAGES), .RST_VAL(BUN_RST)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (bun_raw),
      .q_o   (bun_s)
   );

   assign {mode_bit, le_s, sclk_s, sdata_s, addr_s, par_s} = bun_s;
   assign mode_s = ctl_mode_e'(mode_bit);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         le_q   <= 1'b0;
         sclk_q <= 1'b0;
      end else begin
         le_q   <= le_s;
         sclk_q <= sclk_s;
      end
   end

   assign le_rise   = le_s & ~le_q;
   assign sclk_rise = sclk_s & ~sclk_q;
   assign shift_en  = (mode_s == MODE_SERIAL) & ~le_s & sclk_rise;

   atten_frame_sreg #(.FRAME_W(FRAME_W), .RST_VAL(FRAME_RST)) u_frame (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(shift_en),
      .hold_i (le_s),
      .bit_i  (sdata_s),
      .frame_o(frame)
   );

   atten_state #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_state (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .serial_i (mode_s == MODE_SERIAL),
      .le_i     (le_s),
      .le_rise_i(le_rise),
      .frame_i  (frame),
      .addr_i   (addr_s),
      .par_i    (par_s),
      .code_o   (atten_o)
   );

   // R2: in parallel mode the frame image never moves
   a_r2_parallel_frame_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_s == MODE_PARALLEL) |=> $stable(frame));
endmodule

// File: tb/tb_atten_ctrl.sv
module tb_atten_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_i = 1'b1, le_i = 1'b1, sclk_i = 1'b0, sdata_i = 1'b0;
   logic [2:0] addr_i = 3'b101;
   logic [6:0] par_i = 7'h00;
   logic [6:0] atten_o;

   int    n_chk = 0, n_fail = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   atten_ctrl dut (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_i), .le_i(le_i),
      .sclk_i(sclk_i), .sdata_i(sdata_i), .addr_i(addr_i),
      .par_i(par_i), .atten_o(atten_o)
   );

   // ---------------- behavioural reference model ----------------
   typedef struct packed {
      logic       mode, le, sclk, sdata;
      logic [2:0] addr;
      logic [6:0] par;
   } snap_t;

   localparam snap_t SNAP_RST = '{mode: 1'b1, le: 1'b0, sclk: 1'b0, sdata: 1'b0,
                                  addr: 3'b000, par: 7'h00};

   snap_t      hist[$];
   snap_t      mc, mp;
   logic [15:0] m_frame;
   logic [6:0]  m_att;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist    = {SNAP_RST, SNAP_RST, SNAP_RST};
         m_frame = 16'h007F;
         m_att   = 7'h7F;
      end else begin
         hist.push_back('{mode: mode_i, le: le_i, sclk: sclk_i, sdata: sdata_i,
                          addr: addr_i, par: par_i});
         while (hist.size() > 4) void'(hist.pop_front());
         mc = hist[hist.size()-3];
         mp = hist[hist.size()-4];
         if (mc.mode) begin
            if (mc.le && !mp.le) begin
               if (m_frame[10:8] == mc.addr) m_att = m_frame[6:0];
            end else if (!mc.le && mc.sclk && !mp.sclk) begin
               m_frame = {mc.sdata, m_frame[15:1]};
            end
         end else if (mc.le) begin
            m_att = mc.par;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (atten_o !== m_att) begin
            n_fail++;
            $display("FAIL %s (per-clock model): atten_o=%0h expected %0h", cur_req, atten_o, m_att);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input logic [6:0] exp, input string req);
      n_chk++;
      if (atten_o !== exp) begin
         n_fail++;
         $display("FAIL %s: atten_o=%0h expected %0h", req, atten_o, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bits(input logic [31:0] v, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sdata_i = v[i];
         sclk_i  = 1'b0;
         wait_cyc(2);
         sclk_i  = 1'b1;
         wait_cyc(3);
         sclk_i  = 1'b0;
      end
   endtask

   task automatic pulse_le();
      @(negedge clk);
      le_i = 1'b0;
      wait_cyc(3);
      le_i = 1'b1;
      wait_cyc(5);
   endtask

   task automatic send_frame(input logic [31:0] v, input int n);
      @(negedge clk);
      le_i = 1'b0;
      wait_cyc(3);
      shift_bits(v, n);
      wait_cyc(3);
      le_i = 1'b1;
      wait_cyc(5);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL all requirements: watchdog expired, actual=running expected=finished");
      finish_run();
   end

   // ---------------- directed sequence ----------------
   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(6);
      cur_req = "R1";
      chk(7'h7F, "R1 reset code, default frame address 000 does not match strap 101");

      cur_req = "R3";
      send_frame({16'h0, 8'b11011_101, 8'h96}, 16);
      chk(7'h16, "R3 LSB-first frame, bit7 of word dropped; R4 upper address bits ignored");

      cur_req = "R5";
      send_frame({16'h0, 8'h04, 8'h33}, 16);
      chk(7'h16, "R5 address mismatch keeps code");

      cur_req = "R4";
      send_frame({16'h0, 8'b00000_101, 8'h00}, 16);
      chk(7'h00, "R4 match loads minimum code");

      cur_req = "R10";
      send_frame({15'h0, 8'hAD, 8'h09, 1'b1}, 17);
      chk(7'h09, "R10 surplus first bit drops out");
      send_frame({24'h0, 8'h05}, 8);
      chk(7'h2D, "R10 short burst keeps older bits in low byte");

      cur_req = "R6";
      send_frame({16'h0, 8'h05, 8'h11}, 16);
      chk(7'h11, "R6 setup frame loaded");
      @(negedge clk);
      mode_i = 1'b0;
      par_i  = 7'h7A;
      wait_cyc(5);
      cur_req = "R7";
      chk(7'h7A, "R7 direct parallel with LE high");
      @(negedge clk);
      mode_i = 1'b1;
      wait_cyc(5);
      cur_req = "R6";
      shift_bits(32'hFFFF_FFFF, 16);
      wait_cyc(4);
      chk(7'h7A, "R6 clocks with LE high change nothing");
      pulse_le();
      chk(7'h11, "R6 held frame reloaded by latch edge");

      cur_req = "R9";
      @(negedge clk);
      mode_i = 1'b0;
      wait_cyc(5);
      par_i = 7'h3C;
      wait_cyc(2);
      chk(7'h7A, "R9 no change after second edge");
      wait_cyc(1);
      chk(7'h3C, "R9 change after third edge");

      cur_req = "R8";
      @(negedge clk);
      le_i = 1'b0;
      wait_cyc(4);
      par_i = 7'h01;
      wait_cyc(6);
      chk(7'h3C, "R8 pins ignored while LE low");
      le_i = 1'b1;
      wait_cyc(5);
      chk(7'h01, "R8 LE rise captures pins");

      cur_req = "R2";
      @(negedge clk);
      par_i = 7'h55;
      wait_cyc(5);
      send_frame({16'h0, 8'h05, 8'h22}, 16);
      chk(7'h55, "R2 serial frame ignored in parallel mode");
      @(negedge clk);
      mode_i = 1'b1;
      wait_cyc(5);
      pulse_le();
      chk(7'h11, "R2 frame image untouched by parallel-mode clocks");

      cur_req = "R1";
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(7'h7F, "R1 asynchronous reset mid-run");
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(6);
      chk(7'h7F, "R1 code after second reset");

      finish_run();
   end
endmodule